// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out, in hertz, the frequency that a phase-locked loop produces from its parameter word, and from that the frequency of the peripheral bus clock. A request presents three 32-bit words (the PLL parameter word, the hardware strap word and the clock-select word) and a mode bit, with a one-cycle `start` pulse. A few dozen cycles later the block raises `done` for one cycle. At that point `pll_hz` and `bus_hz` carry the results. They hold their values until the next result.

The reference input frequency comes from two strap bits. Two parameter encodings are supported. The strap-table encoding (mode 0) has a programmed flag. When that flag is clear, the PLL frequency comes from a four-entry table indexed by strap bits. When it is set, the frequency comes from the fields N, OD and D. The M/N/P encoding (mode 1) computes a multiplier from the fields M, N and P. Every division truncates toward zero. All quotients come from one shared iterative restoring divider, which handles one quotient bit per cycle. The product with the reference is kept modulo 2^32.

Top module: `pll_freq_calc`

## Requirements
- R1: The reference frequency is 25 000 000 Hz when strap bit 23 is 1. Otherwise it is 48 000 000 Hz when strap bit 18 is 1, and 24 000 000 Hz when neither bit is set.
- R2: When bit 19 of the parameter word (PLL off) is 1, `pll_hz` is 0 and `bus_hz` is 0 in either mode.
- R3: In mode 1 with bits 19 and 20 both clear, the multiplier is ((M+1)/(N+1))/(P+1). Here M = bits [12:5], N = bits [4:0] and P = bits [18:13], and each division truncates. `pll_hz` = reference × multiplier.
- R4: In mode 0 with bit 18 (programmed) set and bits 19 and 20 clear, the multiplier is (2−OD)·((N+2)/(D+1)) with a truncating division. Here N = bits [10:5], OD = bit 4 and D = bits [3:0]. `pll_hz` = reference × multiplier.
- R5: When bit 20 (bypass) is 1 and bit 19 is 0, `pll_hz` equals the reference frequency. This applies in mode 1, and in mode 0 when bit 18 is also set.
- R6: In mode 0 with bits 18 and 19 clear, `pll_hz` is a table value in MHz × 1 000 000, indexed by strap bits [9:8]. The values for index 0 to 3 are 384, 360, 336 and 408 when strap bit 23 is 0, and 400, 375, 350 and 425 when strap bit 23 is 1.
- R7: `bus_hz` = (`pll_hz` / (clock-select bits [25:23] + 1)) / 2 in mode 0, and / 4 in mode 1. Both divisions truncate.
- R8: Each accepted `start` yields exactly one `done` pulse, one cycle wide. It comes within 3·(FREQ_W+2)+6 cycles (108 at defaults). Between pulses, `pll_hz` and `bus_hz` do not change.
- R9: A `start` that arrives while a calculation is running is ignored. No extra `done` is produced and the running result is unaffected.
- R10: After reset, `done`, `pll_hz` and `bus_hz` are 0.
- R11: The product of reference and multiplier is truncated to its low 32 bits. For example, 48 MHz × 130 yields 1 945 032 704.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; operands are sampled with it |
| mode | input | 1 | 0 = strap-table encoding, 1 = M/N/P encoding |
| pll_word | input | 32 | PLL parameter word |
| strap_word | input | 32 | Hardware strap word |
| clk_sel_word | input | 32 | Clock-select word holding the bus divider field |
| done | output | 1 | One-cycle result strobe |
| pll_hz | output | 32 | PLL output frequency in Hz |
| bus_hz | output | 32 | Peripheral bus frequency in Hz |

## Verification
The assertions assume that `start` is taken only when the block is idle. They keep their own copy of the operands captured on that edge, and they compare the off and bypass results against that copy. They assume nothing about operand values: the divisors are always at least 1 by construction, so every field combination is legal. The stimulus holds operands steady between requests. It issues a second `start` only inside the busy window, on purpose, to show that the request is ignored. Each case waits for `done` before the next request.

// File: rtl/pll_freq_pkg.sv
// Package: shared state type and field layout for the PLL frequency calculator.
// Assumes 32-bit parameter words; field positions here are fixed by the encodings.
package pll_freq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIV1,
        ST_DIV2,
        ST_MUL,
        ST_BUS_GO,
        ST_BUS_WAIT
    } calc_state_e;

    localparam int unsigned REF_24M_HZ = 24_000_000;
    localparam int unsigned REF_25M_HZ = 25_000_000;
    localparam int unsigned REF_48M_HZ = 48_000_000;

    // M/N/P encoding fields
    localparam int MNP_P_LSB = 13;
    localparam int MNP_P_W   = 6;
    localparam int MNP_M_LSB = 5;
    localparam int MNP_M_W   = 8;
    localparam int MNP_N_LSB = 0;
    localparam int MNP_N_W   = 5;

    // strap-table encoding fields
    localparam int TBL_N_LSB  = 5;
    localparam int TBL_N_W    = 6;
    localparam int TBL_OD_BIT = 4;
    localparam int TBL_D_LSB  = 0;
    localparam int TBL_D_W    = 4;

endpackage

// File: rtl/pll_ref_select.sv
// Module: picks the reference input frequency from the strap word.
// Assumes the 25 MHz strap outranks the 48 MHz strap; 24 MHz is the default.
module pll_ref_select #(
    parameter int STRAP_W = 32,
    parameter int FREQ_W  = 32,
    parameter int S25_BIT = 23,
    parameter int S48_BIT = 18
) (
    input  logic [STRAP_W-1:0] strap,
    output logic [FREQ_W-1:0]  ref_hz,
    output logic               is_25m
);
    import pll_freq_pkg::*;

    // priority decode of the two clock-input straps
    always_comb begin
        is_25m = strap[S25_BIT];
        if (strap[S25_BIT])      ref_hz = FREQ_W'(REF_25M_HZ);
        else if (strap[S48_BIT]) ref_hz = FREQ_W'(REF_48M_HZ);
        else                     ref_hz = FREQ_W'(REF_24M_HZ);
    end
endmodule

// File: rtl/pll_strap_table.sv
// Module: strap-selected PLL frequency table for an unprogrammed PLL.
// Assumes a 2-bit select; the row follows the 25 MHz strap (48 MHz uses the 24 MHz row).
module pll_strap_table #(
    parameter int FREQ_W = 32
) (
    input  logic              is_25m,
    input  logic [1:0]        sel,
    output logic [FREQ_W-1:0] hz
);
    localparam int unsigned MHZ = 1_000_000;

    logic [15:0] mhz;

    // table lookup in MHz, then scale to Hz
    always_comb begin
        unique case ({is_25m, sel})
            3'b000:  mhz = 16'd384;
            3'b001:  mhz = 16'd360;
            3'b010:  mhz = 16'd336;
            3'b011:  mhz = 16'd408;
            3'b100:  mhz = 16'd400;
            3'b101:  mhz = 16'd375;
            3'b110:  mhz = 16'd350;
            default: mhz = 16'd425;
        endcase
        hz = FREQ_W'(32'(mhz) * MHZ);
    end
endmodule

// File: rtl/pll_seq_divider.sv
// Module: iterative restoring divider, one quotient bit per cycle.
// Assumes divisor is non-zero and start is only pulsed when the previous result was taken.
// Latency: done is high WIDTH cycles after the start edge, for one cycle.
module pll_seq_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             done,
    output logic [WIDTH-1:0] quotient
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [WIDTH:0]   rem_q;
    logic [WIDTH-1:0] dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   trial;

    // one restoring step: shift in next dividend bit, try subtract
    always_comb begin
        shifted = {rem_q[WIDTH-1:0], quotient[WIDTH-1]};
        trial   = shifted - {1'b0, dvs_q};
    end

    // load on start, iterate while active, strobe done after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q    <= '0;
                dvs_q    <= divisor;
                quotient <= dividend;
                cnt_q    <= CNT_W'(WIDTH);
                active_q <= 1'b1;
            end else if (active_q) begin
                if (!trial[WIDTH]) begin
                    rem_q    <= trial;
                    quotient <= {quotient[WIDTH-2:0], 1'b1};
                end else begin
                    rem_q    <= shifted;
                    quotient <= {quotient[WIDTH-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pll_freq_calc.sv
// Module: top of the PLL frequency calculator. Captures operands on start,
// walks a small sequencer that reuses one divider for the multiplier and bus
// divisions, and publishes both frequencies with a one-cycle done strobe.
// Assumes start is a pulse; starts seen while busy are dropped.
module pll_freq_calc #(
    parameter int FREQ_W       = 32,
    parameter int OFF_BIT      = 19,
    parameter int BYP_BIT      = 20,
    parameter int PROG_BIT     = 18,
    parameter int S25_BIT      = 23,
    parameter int S48_BIT      = 18,
    parameter int FSEL_LSB     = 8,
    parameter int PCLK_LSB     = 23,
    parameter int PCLK_W       = 3,
    parameter int TBL_BUS_LOG2 = 1,
    parameter int MNP_BUS_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [31:0]       pll_word,
    input  logic [31:0]       strap_word,
    input  logic [31:0]       clk_sel_word,
    output logic              done,
    output logic [FREQ_W-1:0] pll_hz,
    output logic [FREQ_W-1:0] bus_hz
);
    import pll_freq_pkg::*;

    calc_state_e       state_q;
    logic              busy;
    logic              cap_mode;
    logic [31:0]       cap_pll;
    logic [31:0]       cap_strap;
    logic [31:0]       cap_clk;
    logic [FREQ_W-1:0] acc_q;
    logic [FREQ_W-1:0] mult_q;

    logic [FREQ_W-1:0] ref_hz;
    logic              is_25m;
    logic [FREQ_W-1:0] tbl_hz;

    logic              div_start;
    logic [FREQ_W-1:0] div_a;
    logic [FREQ_W-1:0] div_b;
    logic              div_done;
    logic [FREQ_W-1:0] div_q;

    logic              f_off;
    logic              f_byp_eff;
    logic              f_table;
    logic [2*FREQ_W-1:0] product;

    assign busy = (state_q != ST_IDLE);

    pll_ref_select #(
        .STRAP_W(32), .FREQ_W(FREQ_W), .S25_BIT(S25_BIT), .S48_BIT(S48_BIT)
    ) u_ref (
        .strap(cap_strap), .ref_hz(ref_hz), .is_25m(is_25m)
    );

    pll_strap_table #(.FREQ_W(FREQ_W)) u_tbl (
        .is_25m(is_25m),
        .sel(cap_strap[FSEL_LSB +: 2]),
        .hz(tbl_hz)
    );

    pll_seq_divider #(.WIDTH(FREQ_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(div_a), .divisor(div_b),
        .done(div_done), .quotient(div_q)
    );

    // classify the captured request into off / bypass / table / computed
    always_comb begin
        f_off     = cap_pll[OFF_BIT];
        f_byp_eff = cap_pll[BYP_BIT] && (cap_mode || cap_pll[PROG_BIT]);
        f_table   = !cap_mode && !cap_pll[PROG_BIT];
        product   = (2*FREQ_W)'(ref_hz) * (2*FREQ_W)'(mult_q);
    end

    // divider operand mux, one source per sequencer step
    always_comb begin
        div_start = 1'b0;
        div_a     = '0;
        div_b     = FREQ_W'(1);
        unique case (state_q)
            ST_PREP: begin
                div_start = !f_off && !f_byp_eff && !f_table;
                if (cap_mode) begin
                    div_a = FREQ_W'(cap_pll[MNP_M_LSB +: MNP_M_W]) + FREQ_W'(1);
                    div_b = FREQ_W'(cap_pll[MNP_N_LSB +: MNP_N_W]) + FREQ_W'(1);
                end else begin
                    div_a = FREQ_W'(cap_pll[TBL_N_LSB +: TBL_N_W]) + FREQ_W'(2);
                    div_b = FREQ_W'(cap_pll[TBL_D_LSB +: TBL_D_W]) + FREQ_W'(1);
                end
            end
            ST_DIV1: begin
                div_start = div_done && cap_mode;
                div_a     = div_q;
                div_b     = FREQ_W'(cap_pll[MNP_P_LSB +: MNP_P_W]) + FREQ_W'(1);
            end
            ST_BUS_GO: begin
                div_start = 1'b1;
                div_a     = acc_q;
                div_b     = FREQ_W'(cap_clk[PCLK_LSB +: PCLK_W]) + FREQ_W'(1);
            end
            default: ;
        endcase
    end

    // sequencer: capture, compute multiplier, scale reference, divide for bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_mode  <= 1'b0;
            cap_pll   <= '0;
            cap_strap <= '0;
            cap_clk   <= '0;
            acc_q     <= '0;
            mult_q    <= '0;
            done      <= 1'b0;
            pll_hz    <= '0;
            bus_hz    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cap_mode  <= mode;
                        cap_pll   <= pll_word;
                        cap_strap <= strap_word;
                        cap_clk   <= clk_sel_word;
                        state_q   <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (f_off) begin
                        acc_q   <= '0;
                        state_q <= ST_BUS_GO;
                    end else if (f_byp_eff) begin
                        acc_q   <= ref_hz;
                        state_q <= ST_BUS_GO;
                    end else if (f_table) begin
                        acc_q   <= tbl_hz;
                        state_q <= ST_BUS_GO;
                    end else begin
                        state_q <= ST_DIV1;
                    end
                end
                ST_DIV1: begin
                    if (div_done) begin
                        if (cap_mode) begin
                            state_q <= ST_DIV2;
                        end else begin
                            mult_q  <= cap_pll[TBL_OD_BIT] ? div_q : (div_q << 1);
                            state_q <= ST_MUL;
                        end
                    end
                end
                ST_DIV2: begin
                    if (div_done) begin
                        mult_q  <= div_q;
                        state_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    acc_q   <= product[FREQ_W-1:0];
                    state_q <= ST_BUS_GO;
                end
                ST_BUS_GO: begin
                    state_q <= ST_BUS_WAIT;
                end
                ST_BUS_WAIT: begin
                    if (div_done) begin
                        pll_hz  <= acc_q;
                        bus_hz  <= cap_mode ? (div_q >> MNP_BUS_LOG2)
                                            : (div_q >> TBL_BUS_LOG2);
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pll_freq_calc_chk.sv
// Checker: temporal properties of pll_freq_calc, bound to every instance.
// Keeps its own copy of the operands taken when an idle block accepts start.
module pll_freq_calc_chk #(
    parameter int FREQ_W  = 32,
    parameter int OFF_BIT = 19,
    parameter int BYP_BIT = 20,
    parameter int PROG_BIT = 18,
    parameter int S25_BIT = 23,
    parameter int S48_BIT = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mode,
    input logic [31:0]       pll_word,
    input logic [31:0]       strap_word,
    input logic              done,
    input logic [FREQ_W-1:0] pll_hz,
    input logic [FREQ_W-1:0] bus_hz
);
    localparam int LAT_MAX = 3 * (FREQ_W + 2) + 6;

    logic        k_mode;
    logic [31:0] k_pll;
    logic [31:0] k_strap;
    logic [15:0] busy_cnt;
    logic [31:0] k_ref;

    // shadow copy of the accepted request and busy-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_mode   <= 1'b0;
            k_pll    <= '0;
            k_strap  <= '0;
            busy_cnt <= '0;
        end else begin
            if (start && !busy) begin
                k_mode  <= mode;
                k_pll   <= pll_word;
                k_strap <= strap_word;
            end
            busy_cnt <= busy ? busy_cnt + 16'd1 : 16'd0;
        end
    end

    // expected reference from the shadow straps
    always_comb begin
        if (k_strap[S25_BIT])      k_ref = 32'd25_000_000;
        else if (k_strap[S48_BIT]) k_ref = 32'd48_000_000;
        else                       k_ref = 32'd24_000_000;
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 16'(LAT_MAX)));

    p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_hold_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pll_hz) && $stable(bus_hz)));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && k_pll[OFF_BIT]) |-> (pll_hz == '0 && bus_hz == '0));

    p_bypass_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !k_pll[OFF_BIT] && k_pll[BYP_BIT] && (k_mode || k_pll[PROG_BIT]))
        |-> (pll_hz == FREQ_W'(k_ref)));

    p_bus_not_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_hz <= pll_hz));
endmodule

bind pll_freq_calc pll_freq_calc_chk #(
    .FREQ_W(FREQ_W), .OFF_BIT(OFF_BIT), .BYP_BIT(BYP_BIT),
    .PROG_BIT(PROG_BIT), .S25_BIT(S25_BIT), .S48_BIT(S48_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mode(mode),
    .pll_word(pll_word), .strap_word(strap_word), .done(done),
    .pll_hz(pll_hz), .bus_hz(bus_hz)
);

// File: tb/pll_freq_calc_tb.sv
// Directed bench for pll_freq_calc: one task per scenario, each checking itself.
module pll_freq_calc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] pll_word = '0;
    logic [31:0] strap_word = '0;
    logic [31:0] clk_sel_word = '0;
    logic        done;
    logic [31:0] pll_hz;
    logic [31:0] bus_hz;

    int n_chk = 0;
    int n_fail = 0;
    localparam int LAT_MAX = 108;

    always #5 clk = ~clk;

    pll_freq_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .pll_word(pll_word), .strap_word(strap_word), .clk_sel_word(clk_sel_word),
        .done(done), .pll_hz(pll_hz), .bus_hz(bus_hz)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // ---- reference model built from the requirements ----
    function automatic logic [31:0] m_ref(input logic [31:0] st);
        if (st[23]) return 32'd25_000_000;
        if (st[18]) return 32'd48_000_000;
        return 32'd24_000_000;
    endfunction

    function automatic logic [31:0] m_table(input logic [31:0] st);
        int unsigned v;
        case ({st[23], st[9:8]})
            3'b000: v = 384; 3'b001: v = 360; 3'b010: v = 336; 3'b011: v = 408;
            3'b100: v = 400; 3'b101: v = 375; 3'b110: v = 350; default: v = 425;
        endcase
        return v * 1_000_000;
    endfunction

    function automatic logic [31:0] m_pll(input logic m, input logic [31:0] pw,
                                          input logic [31:0] st);
        longint unsigned mul;
        longint unsigned r;
        if (pw[19]) return 32'd0;
        if (!m && !pw[18]) return m_table(st);
        if (pw[20]) return m_ref(st);
        if (m) mul = ((longint'(pw[12:5]) + 1) / (longint'(pw[4:0]) + 1)) / (longint'(pw[18:13]) + 1);
        else   mul = (2 - longint'(pw[4])) * ((longint'(pw[10:5]) + 2) / (longint'(pw[3:0]) + 1));
        r = longint'(m_ref(st)) * mul;
        return r[31:0];
    endfunction

    function automatic logic [31:0] m_bus(input logic m, input logic [31:0] p,
                                          input logic [31:0] cs);
        logic [31:0] q;
        q = p / (32'(cs[25:23]) + 32'd1);
        return m ? (q / 4) : (q / 2);
    endfunction

    function automatic logic [31:0] enc_mnp(input int p, input int mm, input int n);
        return (32'(p) << 13) | (32'(mm) << 5) | 32'(n);
    endfunction

    function automatic logic [31:0] enc_tbl(input int n, input int od, input int d);
        return 32'h0004_0000 | (32'(n) << 5) | (32'(od) << 4) | 32'(d);
    endfunction

    // issue one request, wait for done, check latency, pulse width and values
    task automatic run_case(input string req, input logic m, input logic [31:0] pw,
                            input logic [31:0] st, input logic [31:0] cs);
        int cyc;
        logic [31:0] ep;
        ep = m_pll(m, pw, st);
        @(negedge clk);
        mode = m; pll_word = pw; strap_word = st; clk_sel_word = cs; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8", "done seen within bound", 32'(done && cyc <= LAT_MAX), 32'd1);
        chk(req, "pll_hz", pll_hz, ep);
        chk("R7", "bus_hz", bus_hz, m_bus(m, ep, cs));
        @(negedge clk);
        chk("R8", "done one cycle wide", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk("R10", "done after reset", 32'(done), 32'd0);
        chk("R10", "pll_hz after reset", pll_hz, 32'd0);
        chk("R10", "bus_hz after reset", bus_hz, 32'd0);
    endtask

    task automatic t_ref_select();
        // R1: bypass exposes the reference directly; 25 MHz strap wins over 48 MHz
        run_case("R1", 1'b1, 32'h0010_0000, 32'h0000_0000, 32'h0);
        run_case("R1", 1'b1, 32'h0010_0000, 32'h0004_0000, 32'h0);
        run_case("R1", 1'b1, 32'h0010_0000, 32'h0084_0000, 32'h0);
    endtask

    task automatic t_off();
        run_case("R2", 1'b1, 32'h0008_0000 | enc_mnp(1, 95, 3), 32'h0, 32'h0080_0000);
        run_case("R2", 1'b0, 32'h0008_0000 | enc_tbl(10, 0, 1), 32'h0080_0000, 32'h0);
        run_case("R2", 1'b0, 32'h0008_0000, 32'h0, 32'h0);
    endtask

    task automatic t_mnp();
        run_case("R3", 1'b1, enc_mnp(1, 95, 3), 32'h0, 32'h0080_0000);
        run_case("R3", 1'b1, enc_mnp(1, 10, 2), 32'h0080_0000, 32'h0);
        run_case("R3", 1'b1, enc_mnp(0, 255, 0), 32'h0, 32'h0380_0000);
        run_case("R3", 1'b1, enc_mnp(5, 3, 7), 32'h0004_0000, 32'h0);
    endtask

    task automatic t_tbl_prog();
        run_case("R4", 1'b0, enc_tbl(14, 0, 1), 32'h0, 32'h0100_0000);
        run_case("R4", 1'b0, enc_tbl(14, 1, 1), 32'h0080_0000, 32'h0);
        run_case("R4", 1'b0, enc_tbl(5, 0, 3), 32'h0004_0000, 32'h0);
    endtask

    task automatic t_bypass();
        run_case("R5", 1'b0, 32'h0010_0000 | enc_tbl(20, 0, 0), 32'h0004_0000, 32'h0);
        run_case("R5", 1'b1, 32'h0010_0000 | enc_mnp(2, 40, 1), 32'h0080_0000, 32'h0180_0000);
    endtask

    task automatic t_table();
        for (int s = 0; s < 8; s++) begin
            logic [31:0] st;
            st = ((s >= 4) ? 32'h0080_0000 : 32'h0) | (32'(s % 4) << 8);
            run_case("R6", 1'b0, 32'h0010_0000, st, 32'h0);
        end
        run_case("R6", 1'b0, 32'h0, 32'h0004_0300, 32'h0100_0000);
    endtask

    task automatic t_bus_div();
        for (int d = 0; d < 8; d++)
            run_case("R7", d[0], 32'h0010_0000, 32'h0, 32'(d) << 23);
    endtask

    task automatic t_wrap();
        run_case("R11", 1'b0, enc_tbl(63, 0, 0), 32'h0004_0000, 32'h0);
        chk("R11", "wrapped product", pll_hz, 32'd1_945_032_704);
    endtask

    task automatic t_hold();
        logic [31:0] p0, b0;
        p0 = pll_hz; b0 = bus_hz;
        @(negedge clk);
        mode = ~mode; pll_word = 32'hFFFF_FFFF; strap_word = 32'h1234_5678;
        repeat (20) @(negedge clk);
        chk("R8", "pll_hz held without start", pll_hz, p0);
        chk("R8", "bus_hz held without start", bus_hz, b0);
    endtask

    task automatic t_busy_ignore();
        int dones;
        logic [31:0] pw, st, ep;
        pw = enc_mnp(1, 95, 3); st = 32'h0; ep = m_pll(1'b1, pw, st);
        dones = 0;
        @(negedge clk);
        mode = 1'b1; pll_word = pw; strap_word = st; clk_sel_word = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        mode = 1'b0; pll_word = 32'h0008_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 2 * LAT_MAX; c++) begin
            if (done) begin
                dones++;
                chk("R9", "result of first request", pll_hz, ep);
            end
            @(negedge clk);
        end
        chk("R9", "done count for two starts while busy", 32'(dones), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ref_select();
        t_off();
        t_mnp();
        t_tbl_prog();
        t_bypass();
        t_table();
        t_bus_div();
        t_wrap();
        t_hold();
        t_busy_ignore();
        summary();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end
endmodule